// File: doc/BRIEF.md
# Ordered Key Word Access Gate

The block guards a protected information region (its system and user areas, for both reading and writing) behind one write-only bus register. Software opens the region by writing three fixed 32-bit key words to that register in a prescribed order. When the final key is captured, a single access output goes high. It stays high until the next write to the register, which closes the gate again whatever value it carries.

Progress through the key sequence is held in a small state machine. A word that is not the key expected next sends the machine back to the start. A stray word that happens to equal the first key is taken as a fresh first key. The write that closes the gate is never counted as a key, so reopening always takes all three words. Reads of the register return zero in every state, so the key position and the gate state cannot be observed on the bus.

Top module: `infoblk_key_gate`

## Requirements
- R1: After reset, and after any reset that lands in the middle of a sequence, `access_o` is 0 and the sequence starts again from the first key.
- R2: Writing 0x3A7F5CA3, then 0xA1E34F20, then 0x9608B2C1 to offset 0x40 while the gate is closed drives `access_o` high on the clock edge that captures the third write.
- R3: A write to offset 0x40 whose data is neither the key expected next nor the first key returns the sequence to its start, so the keys already accepted are lost.
- R4: A mismatching word equal to the first key (0x3A7F5CA3) is accepted as the first key of a new attempt.
- R5: While `access_o` is high, any write to offset 0x40 drops `access_o` on the capturing edge. That write does not count as the first key, even when it equals it.
- R6: Writes to any offset other than 0x40 leave both `access_o` and the sequence position unchanged.
- R7: `rd_data_o` is zero in every state.
- R8: With no write to offset 0x40, `access_o` holds its value.
- R9: The three keys in any order other than the prescribed one do not raise `access_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Bus write strobe, one cycle per write |
| wr_addr_i | input | 8 | Byte offset of the write |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data of the register, always zero |
| access_o | output | 1 | High while access to the protected region is granted |

## Verification
Every cycle, the assertions check four things: a rising `access_o` follows a captured write of the last key from the last sequence position; a write while open closes the gate and clears the position; a stray first key lands on the second position; and a mismatching word empties the position. They also check that `access_o` never moves without a decoded write, which covers the ignored offsets. Only the bench scenarios can show the behaviours that play out over several writes. These are: the full three-word sequence reopening the gate only after a relock; sequences broken at each step; out-of-order keys; a reset in the middle of a sequence; and reads returning zero while the gate is open.

// File: rtl/infoblk_key_pkg.sv
package infoblk_key_pkg;

    localparam int unsigned KEY_W   = 32;
    localparam int unsigned KEY_CNT = 3;
    localparam int unsigned POS_W   = $clog2(KEY_CNT);

    typedef logic [KEY_W-1:0] key_word_t;

    // Ordered key words; position 0 is written first.
    localparam key_word_t ACCESS_KEYS [KEY_CNT] = '{
        32'h3A7F5CA3,
        32'hA1E34F20,
        32'h9608B2C1
    };

    typedef struct packed {
        logic [POS_W-1:0] pos;   // index of the key expected next
        logic             open;  // access granted
    } gate_state_t;

endpackage

// File: rtl/infoblk_key_match.sv
module infoblk_key_match
    import infoblk_key_pkg::*;
(
    input  key_word_t          word_i,
    output logic [KEY_CNT-1:0] match_o
);

    for (genvar k = 0; k < KEY_CNT; k++) begin : g_cmp
        assign match_o[k] = (word_i == ACCESS_KEYS[k]);
    end

endmodule

// File: rtl/infoblk_key_fsm.sv
module infoblk_key_fsm
    import infoblk_key_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               hit_i,
    input  logic [KEY_CNT-1:0] match_i,
    output logic [POS_W-1:0]   pos_o,
    output logic               open_o
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(KEY_CNT - 1);
    localparam logic [POS_W-1:0] ONE_POS  = POS_W'(1);

    gate_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hit_i) begin
            if (st_q.open) begin
                // relock; this word never starts a new sequence
                st_d.open = 1'b0;
                st_d.pos  = '0;
            end else if (match_i[st_q.pos]) begin
                if (st_q.pos == LAST_POS) begin
                    st_d.open = 1'b1;
                    st_d.pos  = '0;
                end else begin
                    st_d.pos = st_q.pos + ONE_POS;
                end
            end else if (match_i[0]) begin
                st_d.pos = ONE_POS;
            end else begin
                st_d.pos = '0;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '{pos: '0, open: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pos_o  = st_q.pos;
    assign open_o = st_q.open;

endmodule

// File: rtl/infoblk_key_gate.sv
module infoblk_key_gate
    import infoblk_key_pkg::*;
#(
    parameter int unsigned          ADDR_W   = 8,
    parameter logic [ADDR_W-1:0]    GATE_OFS = 8'h40
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [KEY_W-1:0]  wr_data_i,
    output logic [KEY_W-1:0]  rd_data_o,
    output logic              access_o
);

    logic               wr_hit;
    logic [KEY_CNT-1:0] key_match;
    logic [POS_W-1:0]   key_pos;

    assign wr_hit = wr_en_i && (wr_addr_i == GATE_OFS);

    infoblk_key_match u_match (
        .word_i  (wr_data_i),
        .match_o (key_match)
    );

    infoblk_key_fsm u_fsm (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .hit_i   (wr_hit),
        .match_i (key_match),
        .pos_o   (key_pos),
        .open_o  (access_o)
    );

    // Register contents never leave the block.
    assign rd_data_o = '0;

endmodule

// File: rtl/infoblk_key_gate_chk.sv
module infoblk_key_gate_chk
    import infoblk_key_pkg::*;
(
    input logic             clk_i,
    input logic             rst_ni,
    input logic             wr_hit_i,
    input logic [KEY_W-1:0] wr_data_i,
    input logic [POS_W-1:0] pos_i,
    input logic             access_i
);

    localparam logic [POS_W-1:0] LAST_POS = POS_W'(KEY_CNT - 1);

    // R2: opening only from the last position on the last key
    p_open_on_last_key_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(access_i) |-> ($past(wr_hit_i) && $past(wr_data_i) == ACCESS_KEYS[KEY_CNT-1]
                             && $past(pos_i) == LAST_POS));

    // R3: a stray word empties the sequence
    p_restart_on_miss_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_hit_i && !access_i && wr_data_i != ACCESS_KEYS[pos_i]
         && wr_data_i != ACCESS_KEYS[0]) |=> (pos_i == '0 && !access_i));

    // R4: the first key always lands on the second position
    p_first_key_restarts_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_hit_i && !access_i && wr_data_i == ACCESS_KEYS[0]) |=> (pos_i == POS_W'(1) && !access_i));

    // R5: any write while open closes the gate and is not a key
    p_relock_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_hit_i && access_i) |=> (!access_i && pos_i == '0));

    // R8 (and R6): no decoded write, no change
    p_hold_without_hit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_hit_i |=> ($stable(access_i) && $stable(pos_i)));

endmodule

bind infoblk_key_gate infoblk_key_gate_chk u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_hit_i  (wr_hit),
    .wr_data_i (wr_data_i),
    .pos_i     (key_pos),
    .access_i  (access_o)
);

// File: tb/infoblk_key_gate_tb_top.sv
module infoblk_key_gate_tb_top;

    localparam logic [31:0] K0 = 32'h3A7F5CA3;
    localparam logic [31:0] K1 = 32'hA1E34F20;
    localparam logic [31:0] K2 = 32'h9608B2C1;
    localparam logic [7:0]  OFS = 8'h40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        access;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    bit    exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    infoblk_key_gate dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_data_o (rd_data),
        .access_o  (access)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit exp, input string tag);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // monitor: one expected access value per write cycle
    initial begin
        forever begin
            @(posedge clk);
            if (wr_en) begin
                @(negedge clk);
                check(tag_q.pop_front(), {31'd0, access}, {31'd0, exp_q.pop_front()});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        do_reset();
        check("R1 reset access", {31'd0, access}, 32'd0);
        check("R7 read zero locked", rd_data, 32'd0);

        // R2 basic unlock
        wr(OFS, K0, 0, "R2 key0");
        wr(OFS, K1, 0, "R2 key1");
        wr(OFS, K2, 1, "R2 key2 opens");
        check("R7 read zero open", rd_data, 32'd0);

        // R8 hold while idle
        repeat (12) @(negedge clk);
        check("R8 hold open idle", {31'd0, access}, 32'd1);

        // R5 relock with first key, which must not count
        wr(OFS, K0, 0, "R5 relock with key0");
        wr(OFS, K1, 0, "R5 key1 after relock");
        wr(OFS, K2, 0, "R5 key2 after relock stays closed");
        wr(OFS, K0, 0, "R5 key0");
        wr(OFS, K1, 0, "R5 key1");
        wr(OFS, K2, 1, "R5 reopen");
        wr(OFS, 32'h0000_1234, 0, "R5 relock arbitrary");

        // R3 broken sequences
        wr(OFS, K0, 0, "R3 key0");
        wr(OFS, 32'hDEAD_BEEF, 0, "R3 bad after key0");
        wr(OFS, K1, 0, "R3 key1 lost");
        wr(OFS, K2, 0, "R3 key2 lost");
        wr(OFS, K0, 0, "R3 key0 b");
        wr(OFS, K1, 0, "R3 key1 b");
        wr(OFS, 32'h0, 0, "R3 bad after key1");
        wr(OFS, K2, 0, "R3 key2 after bad");

        // R4 repeated first key
        wr(OFS, K0, 0, "R4 key0");
        wr(OFS, K0, 0, "R4 key0 again");
        wr(OFS, K1, 0, "R4 key1");
        wr(OFS, K2, 1, "R4 key2 opens");
        wr(OFS, 32'hFFFF_FFFF, 0, "R4 relock");
        wr(OFS, K0, 0, "R4 key0 c");
        wr(OFS, K1, 0, "R4 key1 c");
        wr(OFS, K0, 0, "R4 key0 in third slot");
        wr(OFS, K1, 0, "R4 key1 d");
        wr(OFS, K2, 1, "R4 key2 d opens");
        wr(OFS, 32'h5, 0, "R4 relock d");

        // R9 out of order; the trailing first key then seeds a sequence (R4)
        wr(OFS, K2, 0, "R9 key2 first");
        wr(OFS, K1, 0, "R9 key1 second");
        wr(OFS, K1, 0, "R9 key1 repeat");
        wr(OFS, K2, 0, "R9 key2 again");
        wr(OFS, K0, 0, "R9 key0 last");
        wr(OFS, K1, 0, "R9 key1 after key0");
        wr(OFS, K2, 1, "R9 key2 opens");
        wr(OFS, 32'h7, 0, "R9 relock");

        // R6 other offsets ignored
        wr(OFS, K0, 0, "R6 key0");
        wr(OFS, K1, 0, "R6 key1");
        wr(8'h44, K2, 0, "R6 key2 wrong offset ignored");
        wr(8'h00, 32'h1, 0, "R6 junk wrong offset ignored");
        wr(OFS, K2, 1, "R6 key2 keeps progress");
        wr(8'h00, 32'h1, 1, "R6 wrong offset no relock");
        wr(8'hC0, K0, 1, "R6 aliasing offset no relock");
        wr(OFS, 32'h9, 0, "R6 relock");

        // R1 reset mid-sequence
        wr(OFS, K0, 0, "R1 key0");
        wr(OFS, K1, 0, "R1 key1");
        do_reset();
        check("R1 access after mid reset", {31'd0, access}, 32'd0);
        wr(OFS, K2, 0, "R1 key2 after reset");
        wr(OFS, K0, 0, "R1 key0 b");
        wr(OFS, K1, 0, "R1 key1 b");
        wr(OFS, K2, 1, "R1 full sequence opens");
        do_reset();
        check("R1 reset closes gate", {31'd0, access}, 32'd0);

        repeat (4) @(negedge clk);
        check("R2 scoreboard drained", exp_q.size(), 32'd0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule